// File: doc/BRIEF.md
# Real-Time Counter with Alarm and Periodic Timer

This block is a timer peripheral. It holds a free-running real-time counter that advances once for each cycle of a 32.768 kHz tick enable. The counter is built as two stages: a wide low stage and a narrow high stage that takes the carry. Because the tick rate is 2^15 per second, the count shifted right by 15 bits is elapsed whole seconds. A compare register of the same width raises an alarm pulse when the counter reaches it. A separate periodic down-counter runs from its own tick enable, reloads itself and pulses once per period.

Software drives the block through a small register port. Six word addresses hold the control bits, the two counter halves for reading, the two alarm halves for writing, and the periodic reload value. To read a coherent count, software reads the low half first and the high half second. Each of the three interrupt outputs is a one-cycle pulse that goes to an external interrupt controller.

Top module: `rtc_alarm_timer`

## Requirements
- R1: After reset the counter is 0, every register reads 0 and no interrupt output is high. A control value of 0 turns every feature off: the periodic timer is disabled and there is no freeze and no clear. Control bits are: bit0 periodic enable, bit1 freeze high stage, bit2 freeze low stage, bit3 freeze periodic, bit4 counter clear.
- R2: In each cycle with `rtc_tick_i` high the counter increases by one. In other cycles it holds its value. `rdata_o` is combinational from `addr_i`. Address 1 returns the low stage and address 0 returns the control register.
- R3: When the low stage is all ones and advances, it wraps to zero and the high stage increases by one.
- R4: A read cycle (`rd_en_i` high) at address 1 copies the high stage into a shadow register. Address 2 returns that shadow copy, not the live high stage.
- R5: While control bit2 is set, the low stage holds on every tick and passes no carry to the high stage.
- R6: While control bit1 is set, the high stage holds and the low stage keeps counting and wrapping.
- R7: While control bit4 is set, the counter is forced to zero and stays there. Once the bit is cleared, counting resumes from zero.
- R8: The alarm value is written at address 3 (low part) and address 4 (high part). `irq_alarm_o` pulses for one cycle in the cycle after the counter becomes equal to the alarm value. No further pulse occurs while the counter stays equal.
- R9: `irq_roll_o` pulses for one cycle in the cycle after the full counter wraps from all ones to zero.
- R10: The reload value R is written at address 5. With bit0 set, the periodic counter starts at R and `irq_per_o` pulses for one cycle every R+1 cycles of `tmr_tick_i`. The first pulse comes R+1 ticks after enable.
- R11: With bit0 clear or bit3 set, `tmr_tick_i` produces no periodic pulse. When the freeze is released, counting continues from the held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rtc_tick_i | input | 1 | 32.768 kHz counter advance enable |
| tmr_tick_i | input | 1 | Periodic timer tick enable |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (drives shadow capture) |
| addr_i | input | 3 | Register word address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i` |
| irq_roll_o | output | 1 | Counter wrap pulse |
| irq_alarm_o | output | 1 | Alarm match pulse |
| irq_per_o | output | 1 | Periodic expiry pulse |

## Verification
The alarm match and the counter wrap can fire on the same tick when the alarm is programmed to zero. The bench sets the alarm to zero and then ticks the counter, one tick at a time, up to its full range. It records the tick index of each alarm pulse and each wrap pulse, and checks that both indices equal the number of ticks that were left before the wrap. The bench instance uses a narrow counter (4-bit high stage, 8-bit low stage), so carry, freeze across a wrap and the full rollover all fit within a short run.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned CTRL_W = 5;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_RTC_LO = 3'd1,
    A_RTC_HI = 3'd2,
    A_ALM_LO = 3'd3,
    A_ALM_HI = 3'd4,
    A_RELOAD = 3'd5
  } reg_addr_e;

  // bit0 = per_en ... bit4 = clr
  typedef struct packed {
    logic clr;
    logic frz_per;
    logic frz_lo;
    logic frz_hi;
    logic per_en;
  } ctrl_t;
endpackage

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int unsigned HI_W = 8,
  parameter int unsigned LO_W = 32,
  localparam int unsigned CNT_W = HI_W + LO_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic             frz_hi_i,
  input  logic             frz_lo_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] nxt_o,
  output logic             roll_o
);
  localparam logic [LO_W-1:0] LO_ONE = 1;
  localparam logic [HI_W-1:0] HI_ONE = 1;

  logic [LO_W-1:0] lo_q, lo_d;
  logic [HI_W-1:0] hi_q, hi_d;
  logic adv_lo, adv_hi;

  assign adv_lo = tick_i && !frz_lo_i;
  assign adv_hi = adv_lo && (&lo_q) && !frz_hi_i;

  always_comb begin
    lo_d = adv_lo ? lo_q + LO_ONE : lo_q;
    hi_d = adv_hi ? hi_q + HI_ONE : hi_q;
    if (clr_i) begin
      lo_d = '0;
      hi_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= '0;
      hi_q   <= '0;
      roll_o <= 1'b0;
    end else begin
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      roll_o <= !clr_i && adv_hi && (&hi_q);
    end
  end

  assign cnt_o = {hi_q, lo_q};
  assign nxt_o = {hi_d, lo_d};
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int unsigned CNT_W = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] nxt_i,
  input  logic [CNT_W-1:0] alarm_i,
  output logic             irq_o
);
  // fire only on the edge where the count becomes equal
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= (nxt_i != cnt_i) && (nxt_i == alarm_i);
  end
endmodule

// File: rtl/per_timer.sv
module per_timer #(
  parameter int unsigned PER_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             frz_i,
  input  logic [PER_W-1:0] reload_i,
  output logic [PER_W-1:0] cnt_o,
  output logic             irq_o
);
  localparam logic [PER_W-1:0] ONE = 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      irq_o <= 1'b0;
    end else if (!en_i) begin
      cnt_o <= reload_i;
      irq_o <= 1'b0;
    end else if (tick_i && !frz_i) begin
      if (cnt_o == '0) begin
        cnt_o <= reload_i;
        irq_o <= 1'b1;
      end else begin
        cnt_o <= cnt_o - ONE;
        irq_o <= 1'b0;
      end
    end else begin
      irq_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_alarm_timer.sv
module rtc_alarm_timer
  import rtc_pkg::*;
#(
  parameter int unsigned HI_W   = 8,
  parameter int unsigned LO_W   = 32,
  parameter int unsigned PER_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rtc_tick_i,
  input  logic              tmr_tick_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_roll_o,
  output logic              irq_alarm_o,
  output logic              irq_per_o
);
  localparam int unsigned CNT_W = HI_W + LO_W;

  ctrl_t            ctrl_q;
  logic [HI_W-1:0]  alarm_hi_q, shadow_hi_q;
  logic [LO_W-1:0]  alarm_lo_q;
  logic [PER_W-1:0] reload_q, per_cnt;
  logic [CNT_W-1:0] rtc_cnt, rtc_nxt, alarm_val;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign alarm_val    = {alarm_hi_q, alarm_lo_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q      <= '0;
      alarm_hi_q  <= '0;
      alarm_lo_q  <= '0;
      reload_q    <= '0;
      shadow_hi_q <= '0;
    end else begin
      if (wr_en_i) begin
        case (addr_i)
          A_CTRL:   ctrl_q     <= ctrl_t'(wdata_i[CTRL_W-1:0]);
          A_ALM_LO: alarm_lo_q <= wdata_i[LO_W-1:0];
          A_ALM_HI: alarm_hi_q <= wdata_i[HI_W-1:0];
          A_RELOAD: reload_q   <= wdata_i[PER_W-1:0];
          default: ;
        endcase
      end
      if (rd_en_i && addr_i == A_RTC_LO) shadow_hi_q <= rtc_cnt[CNT_W-1:LO_W];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:   rdata_o[CTRL_W-1:0] = ctrl_q;
      A_RTC_LO: rdata_o[LO_W-1:0]   = rtc_cnt[LO_W-1:0];
      A_RTC_HI: rdata_o[HI_W-1:0]   = shadow_hi_q;
      A_ALM_LO: rdata_o[LO_W-1:0]   = alarm_lo_q;
      A_ALM_HI: rdata_o[HI_W-1:0]   = alarm_hi_q;
      A_RELOAD: rdata_o[PER_W-1:0]  = reload_q;
      default: ;
    endcase
  end

  rtc_counter #(.HI_W(HI_W), .LO_W(LO_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (rtc_tick_i),
    .clr_i    (ctrl_q.clr),
    .frz_hi_i (ctrl_q.frz_hi),
    .frz_lo_i (ctrl_q.frz_lo),
    .cnt_o    (rtc_cnt),
    .nxt_o    (rtc_nxt),
    .roll_o   (irq_roll_o)
  );

  rtc_alarm_cmp #(.CNT_W(CNT_W)) u_alm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cnt_i   (rtc_cnt),
    .nxt_i   (rtc_nxt),
    .alarm_i (alarm_val),
    .irq_o   (irq_alarm_o)
  );

  per_timer #(.PER_W(PER_W)) u_per (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tmr_tick_i),
    .en_i     (ctrl_q.per_en),
    .frz_i    (ctrl_q.frz_per),
    .reload_i (reload_q),
    .cnt_o    (per_cnt),
    .irq_o    (irq_per_o)
  );
endmodule

// File: rtl/rtc_alarm_timer_chk.sv
module rtc_alarm_timer_chk #(
  parameter int unsigned HI_W  = 8,
  parameter int unsigned LO_W  = 32,
  parameter int unsigned PER_W = 16,
  localparam int unsigned CNT_W = HI_W + LO_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rtc_tick_i,
  input logic [4:0]       ctrl,
  input logic [CNT_W-1:0] rtc_q,
  input logic [CNT_W-1:0] alarm_q,
  input logic [PER_W-1:0] reload_q,
  input logic [PER_W-1:0] per_q,
  input logic             irq_roll,
  input logic             irq_alarm,
  input logic             irq_per
);
  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rtc_tick_i && !ctrl[4] |=> $stable(rtc_q));

  assert_lo_frozen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl[2] && !ctrl[4] |=> $stable(rtc_q[LO_W-1:0]));

  assert_clear_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl[4] |=> rtc_q == '0);

  assert_alarm_equal_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_alarm && $stable(alarm_q) |-> rtc_q == alarm_q);

  assert_alarm_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_alarm |=> !irq_alarm || !$stable(alarm_q));

  assert_roll_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_roll |-> rtc_q == '0);

  assert_per_reload_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_per && $stable(reload_q) |-> per_q == reload_q);

  assert_per_off_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl[0] |=> !irq_per);

  assert_per_frozen_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl[0] && ctrl[3] |=> $stable(per_q) && !irq_per);
endmodule

bind rtc_alarm_timer rtc_alarm_timer_chk #(.HI_W(HI_W), .LO_W(LO_W), .PER_W(PER_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rtc_tick_i (rtc_tick_i),
  .ctrl       (ctrl_q),
  .rtc_q      (rtc_cnt),
  .alarm_q    (alarm_val),
  .reload_q   (reload_q),
  .per_q      (per_cnt),
  .irq_roll   (irq_roll_o),
  .irq_alarm  (irq_alarm_o),
  .irq_per    (irq_per_o)
);

// File: tb/rtc_alarm_timer_test.sv
module rtc_alarm_timer_test;
  localparam int unsigned HI_W = 4, LO_W = 8, PER_W = 8, DATA_W = 32;
  localparam logic [7:0] PER_VEC [4] = '{8'd0, 8'd1, 8'd5, 8'd17};

  logic clk = 1'b0, rst_n = 1'b0;
  logic rtc_tick = 1'b0, tmr_tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0, rdata;
  logic irq_roll, irq_alarm, irq_per;

  int total = 0, failed = 0;
  int rt_idx = 0, alarm_cnt = 0, alarm_at = -1, roll_cnt = 0, roll_at = -1;
  logic per_hit;

  always #2 clk = ~clk;

  rtc_alarm_timer #(.HI_W(HI_W), .LO_W(LO_W), .PER_W(PER_W), .DATA_W(DATA_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .rtc_tick_i(rtc_tick), .tmr_tick_i(tmr_tick),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_roll_o(irq_roll), .irq_alarm_o(irq_alarm), .irq_per_o(irq_per));

  task automatic check(input string tag, input longint got, input longint exp);
    total++;
    if (got != exp) begin
      failed++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic rtick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rtc_tick = 1'b1;
      @(negedge clk); rtc_tick = 1'b0;
      rt_idx++;
      if (irq_alarm) begin alarm_cnt++; alarm_at = rt_idx; end
      if (irq_roll)  begin roll_cnt++;  roll_at  = rt_idx; end
    end
  endtask

  task automatic ttick();
    @(negedge clk); tmr_tick = 1'b1;
    @(negedge clk); tmr_tick = 1'b0;
    per_hit = irq_per;
  endtask

  task automatic per_gap(output int gap);
    gap = 0;
    do begin ttick(); gap++; end while (!per_hit && gap < 300);
  endtask

  initial begin
    #(4 * 200000);
    failed++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int g, hits;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd0, d); check("R1 ctrl", d, 0);
    rd(3'd1, d); check("R1 rtc lo", d, 0);
    rd(3'd2, d); check("R1 rtc hi", d, 0);
    check("R1 irqs", {irq_roll, irq_alarm, irq_per}, 0);

    // R10 vector table: reload -> period R+1
    foreach (PER_VEC[i]) begin
      wr(3'd5, 32'(PER_VEC[i]));
      wr(3'd0, 32'h1);
      per_gap(g); check("R10 first period", g, PER_VEC[i] + 1);
      per_gap(g); check("R10 next period", g, PER_VEC[i] + 1);
      wr(3'd0, 32'h0);
    end

    // R11 frozen, then released, then disabled
    wr(3'd5, 32'd3);
    wr(3'd0, 32'h9);
    hits = 0;
    for (int i = 0; i < 10; i++) begin ttick(); if (per_hit) hits++; end
    check("R11 frozen no pulse", hits, 0);
    wr(3'd0, 32'h1);
    per_gap(g); check("R11 resume period", g, 4);
    wr(3'd0, 32'h0);
    hits = 0;
    for (int i = 0; i < 10; i++) begin ttick(); if (per_hit) hits++; end
    check("R11 disabled no pulse", hits, 0);

    // R2 counting and holding
    rtick(5);
    rd(3'd1, d); check("R2 count 5", d, 5);
    repeat (10) @(negedge clk);
    rd(3'd1, d); check("R2 hold", d, 5);

    // R4 shadow, R3 carry
    rtick(250);
    rd(3'd1, d); check("R2 count 255", d, 255);
    rtick(1);
    rd(3'd2, d); check("R4 shadow stale", d, 0);
    rd(3'd1, d); check("R3 lo wrap", d, 0);
    rd(3'd2, d); check("R3 hi carry", d, 1);

    // R5 low freeze
    wr(3'd0, 32'h4);
    rtick(7);
    rd(3'd1, d); check("R5 lo frozen", d, 0);
    rd(3'd2, d); check("R5 hi unchanged", d, 1);

    // R6 high freeze across low wrap
    wr(3'd0, 32'h2);
    rtick(256);
    rd(3'd1, d); check("R6 lo wrapped", d, 0);
    rd(3'd2, d); check("R6 hi frozen", d, 1);

    // R7 clear and resume
    wr(3'd0, 32'h10);
    rtick(3);
    rd(3'd1, d); check("R7 cleared lo", d, 0);
    rd(3'd2, d); check("R7 cleared hi", d, 0);
    wr(3'd0, 32'h0);
    rtick(2);
    rd(3'd1, d); check("R7 resumed", d, 2);

    // R8 alarm on low part, count now 2
    wr(3'd4, 32'd0); wr(3'd3, 32'd20);
    alarm_cnt = 0; rt_idx = 0;
    rtick(30);
    check("R8 alarm once", alarm_cnt, 1);
    check("R8 alarm tick", alarm_at, 18);
    // count 32; alarm 40 then hold equal via low freeze
    wr(3'd3, 32'd40);
    alarm_cnt = 0; rt_idx = 0;
    rtick(8);
    check("R8 alarm at 40", alarm_at, 8);
    wr(3'd0, 32'h4);
    rtick(5);
    check("R8 no repeat while equal", alarm_cnt, 1);
    wr(3'd0, 32'h0);

    // R8 alarm spanning both halves: 0x205 from 0x28
    wr(3'd4, 32'd2); wr(3'd3, 32'h05);
    alarm_cnt = 0; rt_idx = 0;
    rtick(500);
    check("R8 full-width alarm", alarm_at, 477);

    // R9 rollover together with alarm at zero, count 0x21C
    wr(3'd4, 32'd0); wr(3'd3, 32'd0);
    alarm_cnt = 0; roll_cnt = 0; rt_idx = 0;
    rtick(4096 - 540);
    check("R9 roll once", roll_cnt, 1);
    check("R9 roll tick", roll_at, 3556);
    check("R8 alarm with roll", alarm_at, 3556);
    rd(3'd1, d); check("R9 lo zero", d, 0);
    rd(3'd2, d); check("R9 hi zero", d, 0);

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule